// File: doc/BRIEF.md
# Fair Backplane Bus Requester

This block sits on one master board of a multi-master backplane and handles that board's side of bus arbitration. When local logic needs the bus, the block raises a request on one of several request levels. The level is a static configuration input. The block then waits for the grant to arrive on the daisy chain for that level. When the grant comes, the block absorbs it, drives bus-busy and tells the local master that it owns the bus. A grant that arrives while the board is not requesting is passed down the chain unchanged.

There are two ways to give the bus up, chosen by a mode input. In hold mode the board keeps the bus until the local master has no more work and no transfer is in flight. In yield mode the board also lets go when any other board raises a request, but only once the transfer in flight has finished.

An optional fairness mode stops the block from raising a new request while another board already drives the request line of the same level. In a heavily loaded system this keeps the boards nearest the arbiter from taking the bus every time and starving the boards further down the chain.

Top module: `fair_bus_requester`

## Requirements
- R1: While reset is held, `bus_req_out` is all zeros and `bus_busy_out` and `loc_owner` are low. Because the block is idle, `grant_out` equals `grant_in` on every level.
- R2: When the block is idle, `loc_need` is high and fairness does not block, `bus_req_out` becomes one-hot on bit `cfg_level` one clock later.
- R3: When `cfg_fair` is 1, no new request is raised while `other_req_in[cfg_level]` is 1. Requests seen on other levels do not block. The request is raised one clock after the same-level request clears. When `cfg_fair` is 0, requests from other boards never delay a request.
- R4: While requesting, if `grant_in[cfg_level]` is 1, then one clock later `bus_req_out` is all zeros and both `bus_busy_out` and `loc_owner` are 1.
- R5: When the board is neither requesting nor owning, `grant_out` equals `grant_in`. While it is requesting or owning, `grant_out[cfg_level]` is 0 and every other level passes through unchanged.
- R6: With `cfg_yield` at 0, ownership is held while `loc_need` or `loc_xfer_active` is 1, whatever other boards request. `bus_busy_out` and `loc_owner` drop one clock after both inputs are 0.
- R7: With `cfg_yield` at 1, ownership is held while `loc_xfer_active` is 1. If any bit of `other_req_in` is 1 and no transfer is active, ownership ends one clock later, even while `loc_need` stays high. With no other request, ownership is held while `loc_need` is 1.
- R8: Once raised, a request stays up until its grant arrives, even if `loc_need` drops. If `loc_need` is low at the time of the grant, ownership lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_level | input | LVL_W (2) | Request level of this board, static |
| cfg_fair | input | 1 | 1 = fairness mode on |
| cfg_yield | input | 1 | 1 = yield on another request, 0 = hold until done |
| loc_need | input | 1 | Local master wants the bus |
| loc_xfer_active | input | 1 | Local master has a transfer in flight |
| other_req_in | input | N_LEVELS (4) | Request lines as driven by other boards |
| grant_in | input | N_LEVELS (4) | Daisy-chain grant arriving from upstream |
| grant_out | output | N_LEVELS (4) | Daisy-chain grant passed downstream |
| bus_req_out | output | N_LEVELS (4) | This board's request, one-hot on its level |
| bus_busy_out | output | 1 | Bus-busy driven by this board |
| loc_owner | output | 1 | Tells the local master that it owns the bus |

## Verification
The assertions assume that `cfg_level`, `cfg_fair` and `cfg_yield` are changed only while the block is idle. They also assume that `other_req_in` never contains this board's own request, and that `loc_xfer_active` is raised only while the board owns the bus. The bench changes configuration only between scenarios, after ownership has been released. It drives `other_req_in` and `grant_in` as another board and the arbiter would. It raises a transfer only after it has seen `loc_owner`.

// File: rtl/fbr_pkg.sv
`timescale 1ns/1ps
// Shared types for the fair bus requester.
// Assumes: one requester per board, with three control states.
package fbr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OWN  = 2'd2
    } fbr_state_t;
endpackage

// File: rtl/fbr_fair_gate.sv
`timescale 1ns/1ps
// Fairness gate: reports that a new request must be held back.
// Assumes: other_req_in excludes this board's own request line.
module fbr_fair_gate #(
    parameter int N_LEVELS = 4,
    localparam int LVL_W = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1
) (
    input  logic [LVL_W-1:0]    level,
    input  logic                fair_en,
    input  logic [N_LEVELS-1:0] other_req,
    output logic                blocked
);
    // Block only when fairness is on and our own level is already in use.
    always_comb begin
        blocked = fair_en && other_req[level];
    end
endmodule

// File: rtl/fbr_release.sv
`timescale 1ns/1ps
// Release policy: decides when an owning board gives up the bus.
// Assumes: xfer_active is meaningful only while owning.
module fbr_release #(
    parameter int N_LEVELS = 4
) (
    input  logic                yield_mode,
    input  logic                need,
    input  logic                xfer_active,
    input  logic [N_LEVELS-1:0] other_req,
    output logic                release_now
);
    logic done_w;
    logic contested_w;

    // A release never cuts a transfer short; yield mode also reacts to demand from others.
    always_comb begin
        done_w      = !need;
        contested_w = yield_mode && (|other_req);
        release_now = !xfer_active && (done_w || contested_w);
    end
endmodule

// File: rtl/fbr_grant_chain.sv
`timescale 1ns/1ps
// Daisy-chain grant passing: absorbs the own-level grant while engaged.
// Assumes: level is static while engaged.
module fbr_grant_chain #(
    parameter int N_LEVELS = 4,
    localparam int LVL_W = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1
) (
    input  logic [LVL_W-1:0]    level,
    input  logic                engaged,
    input  logic [N_LEVELS-1:0] grant_in,
    output logic [N_LEVELS-1:0] grant_out
);
    for (genvar g = 0; g < N_LEVELS; g++) begin : g_lvl
        // Pass this level's grant unless this board has claimed it.
        always_comb begin
            grant_out[g] = grant_in[g] && !(engaged && (level == LVL_W'(g)));
        end
    end
endmodule

// File: rtl/fair_bus_requester.sv
`timescale 1ns/1ps
// Fair bus requester: request, grant absorption, bus-busy and release
// for one master board on a multi-level daisy-chained backplane.
// Assumes: configuration inputs change only while idle.
module fair_bus_requester
    import fbr_pkg::*;
#(
    parameter int N_LEVELS = 4,
    localparam int LVL_W = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LVL_W-1:0]    cfg_level,
    input  logic                cfg_fair,
    input  logic                cfg_yield,
    input  logic                loc_need,
    input  logic                loc_xfer_active,
    input  logic [N_LEVELS-1:0] other_req_in,
    input  logic [N_LEVELS-1:0] grant_in,
    output logic [N_LEVELS-1:0] grant_out,
    output logic [N_LEVELS-1:0] bus_req_out,
    output logic                bus_busy_out,
    output logic                loc_owner
);
    fbr_state_t state_q, state_d;
    logic blocked_w;
    logic release_w;
    logic engaged_w;

    fbr_fair_gate #(.N_LEVELS(N_LEVELS)) i_gate (
        .level     (cfg_level),
        .fair_en   (cfg_fair),
        .other_req (other_req_in),
        .blocked   (blocked_w)
    );

    fbr_release #(.N_LEVELS(N_LEVELS)) i_rel (
        .yield_mode  (cfg_yield),
        .need        (loc_need),
        .xfer_active (loc_xfer_active),
        .other_req   (other_req_in),
        .release_now (release_w)
    );

    fbr_grant_chain #(.N_LEVELS(N_LEVELS)) i_chain (
        .level     (cfg_level),
        .engaged   (engaged_w),
        .grant_in  (grant_in),
        .grant_out (grant_out)
    );

    // Next-state selection for request, ownership and release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (loc_need && !blocked_w) state_d = ST_WAIT;
            ST_WAIT: if (grant_in[cfg_level])    state_d = ST_OWN;
            ST_OWN:  if (release_w)              state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Engagement flag used by the grant chain.
    always_comb begin
        engaged_w = (state_q != ST_IDLE);
    end

    // Request line for the configured level only.
    for (genvar g = 0; g < N_LEVELS; g++) begin : g_req
        always_comb begin
            bus_req_out[g] = (state_q == ST_WAIT) && (cfg_level == LVL_W'(g));
        end
    end

    // Ownership outputs.
    always_comb begin
        bus_busy_out = (state_q == ST_OWN);
        loc_owner    = (state_q == ST_OWN);
    end

    assert_req_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_req_out));

    assert_fair_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_out == '0 && !loc_owner && cfg_fair && other_req_in[cfg_level])
        |=> (bus_req_out == '0));

    assert_grant_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_out[cfg_level] && grant_in[cfg_level]) |=> (loc_owner && bus_busy_out));

    assert_no_req_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy_out |-> (bus_req_out == '0));

    assert_grant_absorbed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_req_out != '0) || loc_owner) |-> !grant_out[cfg_level]);

    assert_hold_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_owner && !cfg_yield && (loc_need || loc_xfer_active)) |=> loc_owner);

    assert_xfer_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_owner && loc_xfer_active) |=> loc_owner);

    assert_req_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_out[cfg_level] && !grant_in[cfg_level]) |=> bus_req_out[cfg_level]);
endmodule

// File: tb/test_fair_bus_requester.sv
`timescale 1ns/1ps
// Directed bench for fair_bus_requester; one task per scenario.
module test_fair_bus_requester;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_level;
    logic       cfg_fair, cfg_yield, loc_need, loc_xfer_active;
    logic [3:0] other_req_in, grant_in;
    logic [3:0] grant_out, bus_req_out;
    logic       bus_busy_out, loc_owner;
    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    fair_bus_requester #(.N_LEVELS(4)) i_fair_bus_requester (
        .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_fair(cfg_fair),
        .cfg_yield(cfg_yield), .loc_need(loc_need), .loc_xfer_active(loc_xfer_active),
        .other_req_in(other_req_in), .grant_in(grant_in), .grant_out(grant_out),
        .bus_req_out(bus_req_out), .bus_busy_out(bus_busy_out), .loc_owner(loc_owner)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Request, take grant, release; leaves the block idle.
    task automatic own_bus(input logic [1:0] lvl);
        loc_need = 1'b1;
        tick();
        grant_in = 4'b0001 << lvl;
        tick();
        grant_in = 4'b0000;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cfg_level = 2'd2; cfg_fair = 1'b0; cfg_yield = 1'b0;
        loc_need = 1'b0; loc_xfer_active = 1'b0; other_req_in = 4'b0; grant_in = 4'b1010;
        tick(); tick();
        chk("R1 req", 32'(bus_req_out), 32'h0);
        chk("R1 busy", 32'(bus_busy_out), 32'h0);
        chk("R1 owner", 32'(loc_owner), 32'h0);
        chk("R1 grant pass", 32'(grant_out), 32'ha);
        rst_n = 1'b1; grant_in = 4'b0;
        tick();
    endtask

    task automatic t_forward_idle();
        grant_in = 4'b0100; #1;
        chk("R5 idle pass own level", 32'(grant_out), 32'h4);
        grant_in = 4'b1111; #1;
        chk("R5 idle pass all", 32'(grant_out), 32'hf);
        grant_in = 4'b0000;
    endtask

    task automatic t_hold_mode();
        cfg_yield = 1'b0; loc_need = 1'b1;
        tick();
        chk("R2 request on level 2", 32'(bus_req_out), 32'h4);
        grant_in = 4'b1111; #1;
        chk("R5 absorb while requesting", 32'(grant_out), 32'hb);
        grant_in = 4'b0100;
        tick();
        chk("R4 req dropped", 32'(bus_req_out), 32'h0);
        chk("R4 busy", 32'(bus_busy_out), 32'h1);
        chk("R4 owner", 32'(loc_owner), 32'h1);
        grant_in = 4'b1111; #1;
        chk("R5 absorb while owning", 32'(grant_out), 32'hb);
        grant_in = 4'b0000; other_req_in = 4'b0001;
        tick(); tick(); tick();
        chk("R6 held against other request", 32'(loc_owner), 32'h1);
        loc_need = 1'b0; loc_xfer_active = 1'b1;
        tick();
        chk("R6 held during transfer", 32'(bus_busy_out), 32'h1);
        loc_xfer_active = 1'b0;
        tick();
        chk("R6 released owner", 32'(loc_owner), 32'h0);
        chk("R6 released busy", 32'(bus_busy_out), 32'h0);
        other_req_in = 4'b0000;
        tick();
        chk("R6 no new request", 32'(bus_req_out), 32'h0);
    endtask

    task automatic t_yield_mode();
        cfg_yield = 1'b1;
        own_bus(2'd2);
        chk("R7 owner", 32'(loc_owner), 32'h1);
        tick();
        chk("R7 held with no other request", 32'(loc_owner), 32'h1);
        loc_xfer_active = 1'b1; other_req_in = 4'b1000;
        tick();
        chk("R7 transfer finishes first", 32'(loc_owner), 32'h1);
        loc_xfer_active = 1'b0;
        tick();
        chk("R7 yields while need high", 32'(loc_owner), 32'h0);
        chk("R7 busy off", 32'(bus_busy_out), 32'h0);
        loc_need = 1'b0; other_req_in = 4'b0000;
        tick();
        cfg_yield = 1'b0;
    endtask

    task automatic t_fairness();
        cfg_fair = 1'b1; other_req_in = 4'b0100; loc_need = 1'b1;
        tick(); tick();
        chk("R3 held back by same level", 32'(bus_req_out), 32'h0);
        other_req_in = 4'b0010;
        tick();
        chk("R3 other level does not block", 32'(bus_req_out), 32'h4);
        loc_need = 1'b0; other_req_in = 4'b0000;
        grant_in = 4'b0100;
        tick();
        grant_in = 4'b0000;
        chk("R8 one cycle ownership", 32'(loc_owner), 32'h1);
        tick();
        chk("R8 released", 32'(loc_owner), 32'h0);
        cfg_fair = 1'b0;
    endtask

    task automatic t_fair_off_level0();
        cfg_level = 2'd0; other_req_in = 4'b0001; loc_need = 1'b1;
        tick();
        chk("R3 fairness off not delayed", 32'(bus_req_out), 32'h1);
        loc_need = 1'b0; other_req_in = 4'b0000;
        tick(); tick();
        chk("R8 request kept without need", 32'(bus_req_out), 32'h1);
        grant_in = 4'b0001;
        tick();
        grant_in = 4'b0000;
        chk("R4 owner on level 0", 32'(loc_owner), 32'h1);
        tick();
        chk("R8 release after grant", 32'(loc_owner), 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_forward_idle();
        t_hold_mode();
        t_yield_mode();
        t_fairness();
        t_fair_off_level0();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule